// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a half-duplex serial slave that lets an external host read and write a small configuration register file. The host drives an active-low select, a serial clock and a data line into the block. Read data returns over one of two paths. After reset it uses the shared data line, which the block drives only while it is sending read bytes. When bit 7 of register 0 is set, it uses a dedicated output pin instead.

Every transaction opens with a 16-bit header, sent most significant bit first. Bit 15 is the direction: 1 means read and 0 means write. Bits 14:13 are a length code. Bits 12:0 are the starting register address. Data bytes follow the header, and each byte is sent most significant bit first. The address counts down after each byte.

The serial side runs entirely on the host's clock. Each completed register write toggles a flag, and a two-flop synchronizer carries that flag into the system clock domain. There the block copies the register file into `cfg_q` and raises a one-cycle update strobe.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset every register is 0x00. The port is in three-wire mode, `sdio_oe` and `sdo` are low, `cfg_q` is 0 and `cfg_upd` is low.
- R2: The header is sampled on rising `sclk` edges, MSB first, as {read flag (1 = read), length code[1:0], address[12:0]}.
- R3: Data bytes are sampled MSB first on rising `sclk`. A completed write byte stores into the currently addressed register.
- R4: Length codes 00, 01 and 10 transfer 1, 2 and 3 bytes. Any further bytes in the same transaction write nothing, and the read data path is not driven during them.
- R5: Length code 11 streams bytes until `cs_n` rises.
- R6: After each byte the address decrements by one.
- R7: Only addresses below NREG (default 8) exist. Writes to any other address change nothing and produce no update strobe, and reads from such an address return 0x00.
- R8: In three-wire mode, read bits change on falling `sclk`. `sdio_oe` rises on the first falling edge after the last header bit and stays high only through the read bytes. It is low during header and write phases.
- R9: With register 0 bit 7 set, read data appears on `sdo` and `sdio_oe` stays low. Writes still arrive on `sdio_i`.
- R10: Raising `cs_n` at any point releases `sdio_oe` and discards a partial header or byte. The next transaction starts with a new header.
- R11: `cs_n` may stay low while `sclk` pauses between header and bytes, or between bytes, without disturbing the transfer.
- R12: Each completed write into an existing register makes `cfg_q` take the new register contents, and `cfg_upd` pulses for one `clk` cycle within a few `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the synchronized register copy |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Input side of the shared data line |
| sdio_o | output | 1 | Output value for the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo | output | 1 | Dedicated read data output (four-wire mode) |
| cfg_q | output | NREG*8 | Register file copy in the `clk` domain, register k at bits 8k+7:8k |
| cfg_upd | output | 1 | One-cycle strobe when `cfg_q` is refreshed |

## Verification
A wrong header bit count or a wrong byte counter shows up on the data line at once. The read bytes shift by a bit or come from a neighbouring register, and the drive enable stays high one byte too long or too short, all within the same transaction. A faulty address step or a faulty out-of-range decode surfaces on the next read-back of the affected registers. A lost or doubled write toggle shows within about four system clocks, as a missing or extra update strobe and a stale `cfg_q`.

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave #(
  parameter int NREG = 8,
  parameter int AW   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo,
  output logic [NREG*8-1:0] cfg_q,
  output logic              cfg_upd
);
  localparam int HW = AW + 3;
  localparam int CW = $clog2(HW + 1);
  localparam int IW = $clog2(NREG);

  typedef enum logic [1:0] {S_HDR, S_DATA, S_DONE} st_t;

  st_t            st;
  logic [CW-1:0]  hcnt;
  logic [HW-2:0]  hsh;
  logic           rw;
  logic [1:0]     len, nb;
  logic [AW-1:0]  addr, hdr_addr, rd_addr;
  logic [2:0]     bi;
  logic [6:0]     dsh;
  logic [7:0]     rbyte, nx_byte, wbyte;
  logic [7:0]     regs [NREG];
  logic [NREG*8-1:0] regs_flat;
  logic           abort, four_w, wr_en, wtgl, obit, ract;
  logic [2:0]     sy;

  assign abort    = cs_n | ~rst_n;
  assign four_w   = regs[0][7];
  assign hdr_addr = {hsh[AW-2:0], sdio_i};
  assign rd_addr  = (st == S_HDR) ? hdr_addr : addr - 1'b1;
  assign nx_byte  = (rd_addr < AW'(NREG)) ? regs[rd_addr[IW-1:0]] : 8'h00;
  assign wbyte    = {dsh, sdio_i};
  assign wr_en    = (st == S_DATA) && (bi == 3'd7) && !rw && (addr < AW'(NREG));

  for (genvar k = 0; k < NREG; k++) begin : g_flat
    assign regs_flat[k*8 +: 8] = regs[k];
  end

  always_ff @(posedge sclk or posedge abort) begin
    if (abort) begin
      st <= S_HDR; hcnt <= '0; hsh <= '0; rw <= 1'b0; len <= '0; nb <= '0;
      addr <= '0; bi <= '0; dsh <= '0; rbyte <= '0;
    end else begin
      case (st)
        S_HDR: begin
          hsh  <= {hsh[HW-3:0], sdio_i};
          hcnt <= hcnt + 1'b1;
          if (hcnt == CW'(HW - 1)) begin
            st    <= S_DATA;
            rw    <= hsh[HW-2];
            len   <= hsh[HW-3 -: 2];
            addr  <= hdr_addr;
            bi    <= '0;
            nb    <= '0;
            rbyte <= nx_byte;
          end
        end
        S_DATA: begin
          dsh <= {dsh[5:0], sdio_i};
          bi  <= bi + 1'b1;
          if (bi == 3'd7) begin
            addr  <= addr - 1'b1;
            rbyte <= nx_byte;
            nb    <= nb + 1'b1;
            if (len != 2'b11 && nb == len) st <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs[k] <= 8'h00;
      wtgl <= 1'b0;
    end else if (wr_en) begin
      regs[addr[IW-1:0]] <= wbyte;
      wtgl <= ~wtgl;
    end
  end

  always_ff @(negedge sclk or posedge abort) begin
    if (abort) begin
      obit <= 1'b0;
      ract <= 1'b0;
    end else begin
      ract <= (st == S_DATA) && rw;
      obit <= ((st == S_DATA) && rw) ? rbyte[3'd7 - bi] : 1'b0;
    end
  end

  assign sdio_o  = obit;
  assign sdio_oe = ract & ~four_w;
  assign sdo     = obit & four_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy      <= '0;
      cfg_q   <= '0;
      cfg_upd <= 1'b0;
    end else begin
      sy      <= {sy[1:0], wtgl};
      cfg_upd <= sy[2] ^ sy[1];
      if (sy[2] ^ sy[1]) cfg_q <= regs_flat;
    end
  end

  assert_drive_3wire_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (!cs_n && !regs_flat[7]));

  assert_release_on_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdio_oe);

  assert_copy_has_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> cfg_upd);

  assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd |=> !cfg_upd);

  assert_extra_bytes_inert_R4: assert property (@(posedge sclk) disable iff (abort)
    (st == S_DONE) |=> $stable(regs_flat));

  assert_undef_write_inert_R7: assert property (@(posedge sclk) disable iff (abort)
    (st == S_DATA && bi == 3'd7 && !rw && addr >= AW'(NREG)) |=> $stable(regs_flat));
endmodule

// File: tb/sim_spi_cfg_slave.sv
module sim_spi_cfg_slave;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo, cfg_upd;
  logic [63:0] cfg_q;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic fw = 1'b0;
  int n_chk = 0, n_bad = 0, oe_bad = 0, upd_n = 0;

  spi_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .cfg_q(cfg_q), .cfg_upd(cfg_upd));

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n && cfg_upd) upd_n++;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic din, output logic dout, output logic oe);
    sdio_i = din;
    #20;
    dout = fw ? sdo : sdio_o;
    oe = sdio_oe;
    sclk = 1'b1;
    #20;
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic r, input logic [1:0] ln, input logic [12:0] a,
                      input int n, input int drv, input int gap);
    logic [15:0] hdr;
    logic d, oe;
    hdr = {r, ln, a};
    cs_n = 1'b0;
    #20;
    for (int i = 15; i >= 0; i--) begin
      bitx(hdr[i], d, oe);
      if (oe) oe_bad++;
    end
    for (int b = 0; b < n; b++) begin
      if (gap > 0) #(gap);
      for (int i = 7; i >= 0; i--) begin
        bitx(wbuf[b][i], d, oe);
        rbuf[b][i] = d;
        if (oe !== (r && !fw && b < drv)) oe_bad++;
      end
    end
    #20 cs_n = 1'b1;
    #40;
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] v);
    wbuf[0] = v;
    xfer(1'b0, 2'b00, a, 1, 0, 0);
  endtask

  task automatic t_reset;
    check(cfg_q == 64'h0, "R1 cfg_q", cfg_q, 64'h0);
    check(sdio_oe == 1'b0 && sdo == 1'b0, "R1 outputs", {sdio_oe, sdo}, 0);
    check(cfg_upd == 1'b0, "R1 strobe", cfg_upd, 0);
    xfer(1'b1, 2'b00, 13'd0, 1, 1, 0);
    check(rbuf[0] == 8'h00, "R1 reg0", rbuf[0], 0);
  endtask

  task automatic t_single;
    wr1(13'd3, 8'hA5);
    xfer(1'b1, 2'b00, 13'd3, 1, 1, 0);
    check(rbuf[0] == 8'hA5, "R2 R3 readback", rbuf[0], 8'hA5);
    #200;
    check(cfg_q[31:24] == 8'hA5, "R12 cfg_q", cfg_q[31:24], 8'hA5);
    check(upd_n == 1, "R12 strobe count", upd_n, 1);
  endtask

  task automatic t_multi;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer(1'b0, 2'b10, 13'd6, 3, 0, 0);
    xfer(1'b1, 2'b10, 13'd6, 3, 3, 0);
    check({rbuf[0], rbuf[1], rbuf[2]} == 24'h112233, "R6 R4 three bytes",
          {rbuf[0], rbuf[1], rbuf[2]}, 24'h112233);
  endtask

  task automatic t_overrun;
    wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
    xfer(1'b0, 2'b01, 13'd2, 3, 0, 0);
    xfer(1'b1, 2'b00, 13'd0, 2, 1, 0);
    check(rbuf[0] == 8'h00, "R4 extra byte not written", rbuf[0], 8'h00);
    xfer(1'b1, 2'b01, 13'd2, 2, 2, 0);
    check({rbuf[0], rbuf[1]} == 16'h4455, "R4 two bytes", {rbuf[0], rbuf[1]}, 16'h4455);
    check(oe_bad == 0, "R4 no drive after count", oe_bad, 0);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 5; i++) wbuf[i] = 8'h71 + 8'(i);
    xfer(1'b0, 2'b11, 13'd7, 5, 0, 0);
    xfer(1'b1, 2'b11, 13'd7, 8, 8, 0);
    check({rbuf[0], rbuf[1], rbuf[2], rbuf[3]} == 32'h71727374, "R5 stream head",
          {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h71727374);
    check({rbuf[4], rbuf[5], rbuf[6], rbuf[7]} == 32'h75445500, "R5 stream tail",
          {rbuf[4], rbuf[5], rbuf[6], rbuf[7]}, 32'h75445500);
  endtask

  task automatic t_undef;
    int u0n;
    #200;
    u0n = upd_n;
    wr1(13'h020, 8'hFF);
    wr1(13'h1FFF, 8'hFF);
    #200;
    check(upd_n == u0n, "R7 no strobe", upd_n, u0n);
    check(cfg_q == 64'h7172737475445500, "R7 state intact", cfg_q, 64'h7172737475445500);
    xfer(1'b1, 2'b00, 13'h020, 1, 1, 0);
    check(rbuf[0] == 8'h00, "R7 read zero", rbuf[0], 0);
    xfer(1'b1, 2'b10, 13'd8, 3, 3, 0);
    check({rbuf[0], rbuf[1], rbuf[2]} == 24'h007172, "R6 R7 across boundary",
          {rbuf[0], rbuf[1], rbuf[2]}, 24'h007172);
  endtask

  task automatic t_abort;
    logic [15:0] hdr;
    logic d, oe;
    hdr = {1'b0, 2'b00, 13'd2};
    cs_n = 1'b0;
    #20;
    for (int i = 15; i >= 0; i--) bitx(hdr[i], d, oe);
    for (int i = 0; i < 4; i++) bitx(1'b0, d, oe);
    cs_n = 1'b1;
    #40;
    check(sdio_oe == 1'b0, "R10 released", sdio_oe, 0);
    cs_n = 1'b0;
    #20;
    for (int i = 0; i < 7; i++) bitx(1'b1, d, oe);
    cs_n = 1'b1;
    #40;
    xfer(1'b1, 2'b00, 13'd2, 1, 1, 0);
    check(rbuf[0] == 8'h44, "R10 partial byte discarded", rbuf[0], 8'h44);
    xfer(1'b1, 2'b00, 13'd5, 1, 1, 0);
    check(rbuf[0] == 8'h73, "R10 fresh header", rbuf[0], 8'h73);
  endtask

  task automatic t_stall;
    wbuf[0] = 8'h5A;
    xfer(1'b0, 2'b00, 13'd1, 1, 0, 300);
    xfer(1'b1, 2'b01, 13'd1, 2, 2, 300);
    check({rbuf[0], rbuf[1]} == 16'h5A00, "R11 stalled transfer", {rbuf[0], rbuf[1]}, 16'h5A00);
  endtask

  task automatic t_four;
    int b0;
    b0 = oe_bad;
    wr1(13'd0, 8'h80);
    fw = 1'b1;
    xfer(1'b1, 2'b00, 13'd7, 1, 0, 0);
    check(rbuf[0] == 8'h71, "R9 sdo data", rbuf[0], 8'h71);
    check(oe_bad == b0, "R9 shared line idle", oe_bad, b0);
    #200;
    check(cfg_q[7:0] == 8'h80, "R12 mode bit copied", cfg_q[7:0], 8'h80);
    wr1(13'd0, 8'h00);
    fw = 1'b0;
    xfer(1'b1, 2'b00, 13'd0, 1, 1, 0);
    check(rbuf[0] == 8'h00, "R9 back to three-wire", rbuf[0], 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h00;
    #23 rst_n = 1'b1;
    #20;
    t_reset;
    t_single;
    t_multi;
    t_overrun;
    t_stream;
    t_undef;
    t_abort;
    t_stall;
    t_four;
    check(oe_bad == 0, "R8 drive window", oe_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule